// File: doc/BRIEF.md
# Dual Divider Bank Clock Crosspoint

This block is the digital clock fabric that sits behind a frequency synthesizer. It receives a reference clock and a PLL clock and feeds two divider banks. Each bank picks its own source, divides it by a programmable ratio N, and also offers fixed-ratio taps taken from the same counter. Bank 1 offers /2 and /3 taps, and bank 2 offers /2 and /4 taps. A crosspoint then routes one of seven sources to each of six clock outputs, and each output can be gated off on its own.

The fabric runs on one fast clock, `clk_i`. The reference and PLL clocks come in as levels that this clock oversamples. Every output is a registered waveform in the fast-clock domain. All settings arrive as register-byte inputs, in the bit positions given below. The bank ratio and the bank source are captured only at the end of a /N cycle. A reconfiguration therefore never cuts a phase short.

Top module: `clk_fabric`

## Requirements
- R1: While reset is asserted, and after its release until a source is routed and enabled, every output is low.
- R2: Bit 7 of a bank register selects that bank's source: 1 selects the PLL clock and 0 selects the reference clock.
- R3: Bits 6..0 of a bank register hold N, with valid values from 4 to 127. The /N output has a period of N source periods and stays high for the first floor(N/2) of them.
- R4: Route code 000 sends the reference clock straight to the output, bypassing both banks.
- R5: Route codes 001, 010 and 011 select bank 1 divided by N, by 2 and by 3. The /2 tap is high for one source period out of two. The /3 tap is high for one source period out of three.
- R6: Route codes 100, 101 and 110 select bank 2 divided by N, by 2 and by 4. The /4 tap is high for two source periods out of four.
- R7: Route code 111 is reserved, and an output set to it stays low.
- R8: A bank holding N below 4 drives all of its taps low.
- R9: In bank 1, the /2 tap rises in the same cycle as /N when N is a multiple of 4, and the /3 tap does so when N equals 6.
- R10: In bank 2, the /2 tap rises with /N when N is a multiple of 4, and the /4 tap does so when N is a multiple of 8.
- R11: The route input is the concatenation {reg0, reg1, reg2}. Output k (1 to 6) takes its code from bits [23-3(k-1) -: 3], so codes may straddle register boundaries. Bits 5..0 of reg2 are ignored.
- R12: Bit k-1 of the enable register gates output k. A cleared bit holds the output low, standing in for tri-state. Bits 7..6 are ignored.
- R13: A new N or a new bank source takes effect only at the end of the current /N cycle. No high or low phase is shorter than the shorter phase of the old and new settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fabric clock that oversamples both source clocks |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_clk_i | input | 1 | Reference clock level |
| pll_clk_i | input | 1 | PLL clock level |
| cfg_bank1_i | input | 8 | Bank 1: bit 7 source select, bits 6..0 N |
| cfg_bank2_i | input | 8 | Bank 2: bit 7 source select, bits 6..0 N |
| cfg_route_i | input | 24 | Three route registers {reg0, reg1, reg2} holding six 3-bit codes |
| cfg_oe_i | input | 8 | Output enables, bit 0 for output 1 |
| clk_o | output | 6 | Clock outputs, bit 0 is output 1 |

## Verification
The bench builds the block with its default parameters: six outputs, a 7-bit N and 8-bit registers. It drives the reference at 6 fabric cycles per period and the PLL at 2. This separates the two source selections by period alone. It also lets the largest ratio, N=127, complete full output cycles within a short run. With every tap routed at once, the monitor can compare rising edges across outputs in the same sampled cycle. That exposes the alignment conditions on N and the deferral of a ratio change to the /N boundary.

// File: rtl/cf_pkg.sv
package cf_pkg;

  // Crosspoint route codes; the numeric values are part of the register map.
  typedef enum logic [2:0] {
    SRC_REF  = 3'd0,
    SRC_B1_N = 3'd1,
    SRC_B1_2 = 3'd2,
    SRC_B1_F = 3'd3,
    SRC_B2_N = 3'd4,
    SRC_B2_2 = 3'd5,
    SRC_B2_F = 3'd6,
    SRC_OFF  = 3'd7
  } route_e;

  localparam int unsigned ROUTE_W = 3;

  // Taps produced by one divider bank.
  typedef struct packed {
    logic div_n;
    logic div_2;
    logic div_f;
  } taps_t;

endpackage

// File: rtl/cf_edge_det.sv
module cf_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic lvl_o,
  output logic rise_o
);

  logic samp_q;
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      samp_q <= lvl_i;
      prev_q <= samp_q;
    end
  end

  assign lvl_o  = samp_q;
  assign rise_o = samp_q & ~prev_q;

endmodule

// File: rtl/cf_div_bank.sv
module cf_div_bank
  import cf_pkg::*;
#(
  parameter int unsigned N_W     = 7,
  parameter int unsigned FIX_DIV = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N_W:0] cfg_i,
  input  logic         ref_rise_i,
  input  logic         pll_rise_i,
  output taps_t        taps_o
);

  localparam logic [N_W-1:0] N_MIN = N_W'(4);

  logic [N_W-1:0] cnt_q, cnt_d;
  logic [N_W-1:0] n_q, n_d;
  logic           sel_q, sel_d;
  logic           tick, valid, wrap;
  logic           div_n, div_2, div_f;

  // Clock enable: a rising edge of the source in use.
  assign tick  = sel_q ? pll_rise_i : ref_rise_i;
  assign valid = (n_q >= N_MIN);
  assign wrap  = !valid || (cnt_q == n_q - 1'b1);

  // Next state, applied only when tick is high.
  always_comb begin
    cnt_d = cnt_q + 1'b1;
    n_d   = n_q;
    sel_d = sel_q;
    if (wrap) begin
      cnt_d = '0;
      n_d   = cfg_i[N_W-1:0];
      sel_d = cfg_i[N_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      n_q   <= '0;
      sel_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= cnt_d;
      n_q   <= n_d;
      sel_q <= sel_d;
    end
  end

  assign div_n = valid & (cnt_q < (n_q >> 1));
  assign div_2 = valid & ~cnt_q[0];

  generate
    if (FIX_DIV == 3) begin : g_div3
      logic [1:0] ph_q, ph_d;

      always_comb begin
        if (wrap || ph_q == 2'd2) ph_d = 2'd0;
        else                      ph_d = ph_q + 2'd1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    ph_q <= '0;
        else if (tick) ph_q <= ph_d;
      end

      assign div_f = valid & (ph_q == 2'd0);

      // R9: /3 tap rises with /N when N is 6
      p_tap3_align_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(div_n) && $stable(n_q) && (n_q == N_W'(2 * FIX_DIV)) |-> $rose(div_f));
    end else begin : g_pow2
      localparam int unsigned FB = $clog2(FIX_DIV) - 1;

      assign div_f = valid & ~cnt_q[FB];

      // R10: /4 tap rises with /N when N is a multiple of 8
      p_tap4_align_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(div_n) && $stable(n_q) && ((int'(n_q) % (2 * FIX_DIV)) == 0) |-> $rose(div_f));
    end
  endgenerate

  assign taps_o = '{div_n: div_n, div_2: div_2, div_f: div_f};

  // R3: the counter never runs past the active ratio
  p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (cnt_q < n_q));

  // R13: ratio and source change only on a tick that ends a /N cycle
  p_cfg_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && wrap) |=> $stable(n_q) && $stable(sel_q));

  // R9 (and R10 for bank 2): /2 rises with /N when N is a multiple of 4
  p_tap2_align_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(div_n) && $stable(n_q) && (n_q[1:0] == 2'b00) |-> $rose(div_2));

endmodule

// File: rtl/cf_xpoint.sv
module cf_xpoint
  import cf_pkg::*;
#(
  parameter int unsigned NUM_OUT = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ref_lvl_i,
  input  taps_t                      b1_i,
  input  taps_t                      b2_i,
  input  logic [NUM_OUT*ROUTE_W-1:0] sel_i,
  input  logic [NUM_OUT-1:0]         oe_i,
  output logic [NUM_OUT-1:0]         clk_o
);

  generate
    for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
      route_e code;
      logic   pick;
      logic   out_d, out_q;

      assign code = route_e'(sel_i[k*ROUTE_W +: ROUTE_W]);

      always_comb begin
        case (code)
          SRC_REF:  pick = ref_lvl_i;
          SRC_B1_N: pick = b1_i.div_n;
          SRC_B1_2: pick = b1_i.div_2;
          SRC_B1_F: pick = b1_i.div_f;
          SRC_B2_N: pick = b2_i.div_n;
          SRC_B2_2: pick = b2_i.div_2;
          SRC_B2_F: pick = b2_i.div_f;
          default:  pick = 1'b0;
        endcase
        out_d = oe_i[k] & pick;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= 1'b0;
        else        out_q <= out_d;
      end

      assign clk_o[k] = out_q;

      // R7: reserved code yields a low output
      p_rsvd_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i[k*ROUTE_W +: ROUTE_W] == 3'b111) |=> !clk_o[k]);

      // R12: disabled output is held low
      p_oe_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_i[k] |=> !clk_o[k]);
    end
  endgenerate

endmodule

// File: rtl/clk_fabric.sv
module clk_fabric
  import cf_pkg::*;
#(
  parameter int unsigned NUM_OUT = 6,
  parameter int unsigned N_W     = 7,
  parameter int unsigned REG_W   = 8
) (
  input  logic                                                      clk_i,
  input  logic                                                      rst_ni,
  input  logic                                                      ref_clk_i,
  input  logic                                                      pll_clk_i,
  input  logic [REG_W-1:0]                                          cfg_bank1_i,
  input  logic [REG_W-1:0]                                          cfg_bank2_i,
  input  logic [((NUM_OUT*cf_pkg::ROUTE_W+REG_W-1)/REG_W)*REG_W-1:0] cfg_route_i,
  input  logic [REG_W-1:0]                                          cfg_oe_i,
  output logic [NUM_OUT-1:0]                                        clk_o
);

  localparam int unsigned SEL_BITS   = NUM_OUT * ROUTE_W;
  localparam int unsigned ROUTE_REGS = (SEL_BITS + REG_W - 1) / REG_W;
  localparam int unsigned RT_W       = ROUTE_REGS * REG_W;
  localparam int unsigned RT_SPARE   = RT_W - SEL_BITS;
  localparam int unsigned OE_SPARE   = REG_W - NUM_OUT;

  // Asynchronous assertion, synchronous release.
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  logic ref_lvl, ref_rise, pll_lvl, pll_rise;

  cf_edge_det u_ref_edge (
    .clk(clk_i), .rst_n(rst_n), .lvl_i(ref_clk_i), .lvl_o(ref_lvl), .rise_o(ref_rise)
  );

  cf_edge_det u_pll_edge (
    .clk(clk_i), .rst_n(rst_n), .lvl_i(pll_clk_i), .lvl_o(pll_lvl), .rise_o(pll_rise)
  );

  taps_t b1_taps, b2_taps;

  cf_div_bank #(.N_W(N_W), .FIX_DIV(3)) u_bank1 (
    .clk(clk_i), .rst_n(rst_n), .cfg_i(cfg_bank1_i[N_W:0]),
    .ref_rise_i(ref_rise), .pll_rise_i(pll_rise), .taps_o(b1_taps)
  );

  cf_div_bank #(.N_W(N_W), .FIX_DIV(4)) u_bank2 (
    .clk(clk_i), .rst_n(rst_n), .cfg_i(cfg_bank2_i[N_W:0]),
    .ref_rise_i(ref_rise), .pll_rise_i(pll_rise), .taps_o(b2_taps)
  );

  // Output 1 owns the top three route bits, the rest follow MSB-first.
  logic [SEL_BITS-1:0] sel_flat;

  generate
    for (genvar k = 0; k < NUM_OUT; k++) begin : g_unpack
      assign sel_flat[k*ROUTE_W +: ROUTE_W] = cfg_route_i[RT_W-1-k*ROUTE_W -: ROUTE_W];
    end
    if (RT_SPARE > 0) begin : g_rt_spare
      logic unused_route_bits;
      assign unused_route_bits = ^cfg_route_i[RT_SPARE-1:0];
    end
    if (OE_SPARE > 0) begin : g_oe_spare
      logic unused_oe_bits;
      assign unused_oe_bits = ^cfg_oe_i[REG_W-1:NUM_OUT];
    end
  endgenerate

  logic unused_pll_lvl;
  assign unused_pll_lvl = pll_lvl;

  cf_xpoint #(.NUM_OUT(NUM_OUT)) u_xpoint (
    .clk(clk_i), .rst_n(rst_n), .ref_lvl_i(ref_lvl),
    .b1_i(b1_taps), .b2_i(b2_taps),
    .sel_i(sel_flat), .oe_i(cfg_oe_i[NUM_OUT-1:0]), .clk_o(clk_o)
  );

endmodule

// File: tb/sim_clk_fabric.sv
module sim_clk_fabric;

  localparam int CLK_PERIOD = 10;
  localparam int REF_P      = 6;
  localparam int PLL_P      = 2;
  localparam int WATCHDOG   = 150000;

  typedef enum {K_PER, K_FLAT, K_ALIGN, K_MINW} kind_e;
  typedef struct {
    kind_e kind;
    int    a;
    int    b;
    int    v1;
    int    v2;
    int    win;
    string req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_lvl = 1'b0;
  logic        pll_lvl = 1'b0;
  logic [7:0]  b1 = 8'h08;
  logic [7:0]  b2 = 8'h08;
  logic [23:0] route = 24'hFFFFFF;
  logic [7:0]  oe = 8'h00;
  logic [5:0]  clko;

  int    n_run  = 0;
  int    n_fail = 0;
  bit    done   = 1'b0;
  item_t q[$];

  clk_fabric u0 (
    .clk_i(clk), .rst_ni(rst_n), .ref_clk_i(ref_lvl), .pll_clk_i(pll_lvl),
    .cfg_bank1_i(b1), .cfg_bank2_i(b2), .cfg_route_i(route), .cfg_oe_i(oe),
    .clk_o(clko)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Source clocks, changed away from the active edge.
  initial begin
    int rc = 0;
    int pc = 0;
    forever begin
      @(negedge clk);
      rc = (rc + 1) % REF_P;
      pc = (pc + 1) % PLL_P;
      ref_lvl = (rc < REF_P / 2);
      pll_lvl = (pc < PLL_P / 2);
    end
  end

  task automatic check(string req, bit ok, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(kind_e kind, int a, int b, int v1, int v2, int win, string req);
    item_t it;
    it.kind = kind; it.a = a; it.b = b; it.v1 = v1; it.v2 = v2; it.win = win; it.req = req;
    q.push_back(it);
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic expect_item(kind_e kind, int a, int b, int v1, int v2, int win, string req);
    push(kind, a, b, v1, v2, win, req);
    drain();
  endtask

  // Output k is zero-based here (k=0 is output 1).
  task automatic set_route(int k, logic [2:0] code);
    route[23-3*k -: 3] = code;
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops expected items and measures the outputs.
  task automatic run_item(item_t it);
    logic prev_a = clko[it.a];
    logic prev_b = clko[it.b];
    int t_r0 = -1, t_f = -1, t_r1 = -1;
    int highs = 0, rises = 0, mism = 0;
    int last_t = -1, min_w = 1 << 30;
    for (int i = 0; i < it.win; i++) begin
      logic cur_a, cur_b;
      @(negedge clk);
      cur_a = clko[it.a];
      cur_b = clko[it.b];
      if (cur_a) highs++;
      if (!prev_a && cur_a) begin
        rises++;
        if (cur_b === prev_b || !cur_b) mism++;
        if (t_r0 < 0) t_r0 = i;
        else if (t_f >= 0 && t_r1 < 0) t_r1 = i;
      end
      if (prev_a && !cur_a && t_r0 >= 0 && t_f < 0) t_f = i;
      if (prev_a != cur_a) begin
        if (last_t >= 0 && (i - last_t) < min_w) min_w = i - last_t;
        last_t = i;
      end
      prev_a = cur_a;
      prev_b = cur_b;
    end
    case (it.kind)
      K_PER: begin
        int per = (t_r1 >= 0) ? t_r1 - t_r0 : -1;
        int hi  = (t_f >= 0) ? t_f - t_r0 : -1;
        check({it.req, " period"}, per == it.v1, per, it.v1);
        check({it.req, " high time"}, hi == it.v2, hi, it.v2);
      end
      K_FLAT: check({it.req, " output held low"}, highs == 0, highs, 0);
      K_ALIGN: begin
        int act = (rises >= 2) ? mism : -1;
        check({it.req, " rising edges aligned"}, act == 0, act, 0);
      end
      default: begin
        int act = (last_t >= 0) ? min_w : -1;
        check({it.req, " shortest phase"}, act >= it.v1, act, it.v1);
      end
    endcase
  endtask

  initial begin
    forever begin
      while (q.size() == 0) @(negedge clk);
      run_item(q[0]);
      void'(q.pop_front());
    end
  end

  // Watchdog: an expired run counts as a failure and still reports.
  initial begin
    repeat (WATCHDOG) @(negedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: outputs low in reset
    settle(5);
    check("R1 outputs in reset", clko == 6'd0, int'(clko), 0);
    rst_n = 1'b1;
    settle(40);
    check("R1 outputs after release, nothing enabled", clko == 6'd0, int'(clko), 0);

    // Bank 1 from reference with N=8, bank 2 from PLL with N=8.
    b1 = 8'h08;
    b2 = 8'h88;
    set_route(0, 3'b001);
    set_route(1, 3'b010);
    set_route(2, 3'b000);
    set_route(3, 3'b100);
    set_route(4, 3'b101);
    set_route(5, 3'b110);
    oe = 8'hFF;                       // bits 7..6 ignored (R12)
    settle(150);

    expect_item(K_PER, 0, 0, 48, 24, 150, "R3 R5 bank1 /N N=8");
    expect_item(K_PER, 1, 1, 12, 6, 60, "R5 bank1 /2");
    expect_item(K_PER, 2, 2, 6, 3, 30, "R4 R11 reference bypass");
    expect_item(K_PER, 3, 3, 16, 8, 60, "R2 R6 bank2 /N from PLL");
    expect_item(K_PER, 4, 4, 4, 2, 20, "R6 bank2 /2");
    expect_item(K_PER, 5, 5, 8, 4, 30, "R6 R11 bank2 /4");
    expect_item(K_ALIGN, 0, 1, 0, 0, 200, "R9 bank1 /2 vs /N");
    expect_item(K_ALIGN, 3, 4, 0, 0, 80, "R10 bank2 /2 vs /N");
    expect_item(K_ALIGN, 3, 5, 0, 0, 80, "R10 bank2 /4 vs /N");

    // Bank 1 at N=6 with the /3 tap.
    b1 = 8'h06;
    set_route(2, 3'b011);
    settle(120);
    expect_item(K_PER, 0, 0, 36, 18, 120, "R3 bank1 /N N=6");
    expect_item(K_PER, 2, 2, 18, 6, 60, "R5 R11 bank1 /3");
    expect_item(K_ALIGN, 0, 2, 0, 0, 150, "R9 bank1 /3 vs /N");

    // Bank 2 moved to the reference clock.
    b2 = 8'h08;
    settle(60);
    expect_item(K_PER, 3, 3, 48, 24, 150, "R2 bank2 /N from reference");

    // Reserved code and a disabled output.
    set_route(1, 3'b111);
    oe[4] = 1'b0;
    settle(4);
    expect_item(K_FLAT, 1, 1, 0, 0, 60, "R7 reserved code");
    expect_item(K_FLAT, 4, 4, 0, 0, 60, "R12 enable cleared");
    expect_item(K_PER, 5, 5, 24, 12, 80, "R12 R11 neighbour still running");
    oe[4] = 1'b1;

    // Bank 2 below the valid ratio range.
    b2 = 8'h03;
    settle(120);
    expect_item(K_FLAT, 3, 3, 0, 0, 80, "R8 N=3 /N tap");
    expect_item(K_FLAT, 5, 5, 0, 0, 80, "R8 N=3 /4 tap");

    // Ratio change lands on a cycle boundary.
    b1 = 8'h08;
    settle(120);
    push(K_MINW, 0, 0, 12, 0, 300, "R13 N 8 to 4 no runt");
    settle(30);
    b1 = 8'h04;
    drain();
    expect_item(K_PER, 0, 0, 24, 12, 80, "R3 R13 bank1 /N N=4");

    // Largest ratio.
    b1 = 8'h7F;
    settle(60);
    expect_item(K_PER, 0, 0, 762, 378, 1700, "R3 bank1 /N N=127");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule